// File: doc/BRIEF.md
# GPIO interrupt channel multiplexer

This block picks eight interrupt sources out of a wide bank of GPIO pad signals and conditions each one for a downstream interrupt controller that only understands active-high requests. Every output channel has its own 8-bit input selector, a two-flop synchroniser, a programmable glitch filter, an optional inversion and a trigger detector. Level modes give a held level at the output. Edge modes give a one-cycle pulse.

Inversion is applied before detection. A falling edge is therefore a rising edge of the inverted input, and level-low is level-high of the inverted input. A per-channel both-edge bit turns any transition into a pulse and overrides the edge and invert bits. A build parameter removes the both-edge bits altogether. Software sets up the channels through four 32-bit words on a simple word-addressed bus with write enable and a combinational read.

When a write alters a channel's selector or trigger bits, that channel flushes its detector history. The old state of the channel then produces no event.

Top module: `gpio_irq_mux`

## Requirements
- R1: After reset, all four register words read 0x00000000 and every irq_o bit is 0.
- R2: Word 0 holds the edge-enable bit of channel x at bit x, the both-edge bit at bit 8+x and the invert bit at bit 16+x. Bits 31:24 of word 0 read as zero. Word 1 holds the selector of channel x (x = 0..3) at bits [8x+7:8x]. Word 2 holds the selector of channel x (x = 4..7) at bits [8(x-4)+7:8(x-4)]. Word 3 holds a 4-bit filter value of channel x at bits [4x+3:4x]. Every written field reads back unchanged.
- R3: A channel samples pad_i[sel]. A selector value of NUM_IN or more reads as a constant low input.
- R4: A pad change reaches the channel's output on the (3 + max(N,1))-th rising clock edge after the change, where N is the filter value. The input must stay stable over that whole window.
- R5: With filter value N > 0, a pad level that lasts fewer than N cycles after synchronisation is rejected. Values 0 and 1 both accept a single-cycle change.
- R6: With edge = 0 and both = 0, the output holds (pad ^ invert) continuously (level-high or level-low).
- R7: With edge = 1 and both = 0, the output pulses high for exactly one cycle on each rising edge of (pad ^ invert). Invert = 1 gives falling-edge detection.
- R8: With both = 1, the output pulses for one cycle on every transition of the filtered input, whatever the edge and invert bits are.
- R9: When BOTH_EDGE_EN = 0, bits 15:8 of word 0 read as zero and have no effect. The channel then follows only its edge and invert bits.
- R10: A write that changes a channel's selector, edge, both-edge or invert bit causes no output pulse from the old or the new configuration itself. Only a later input transition does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pad_i | input | NUM_IN | GPIO pad interrupt inputs |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| irq_o | output | 8 | Active-high channel requests to the downstream controller |

## Verification
The random phase assigns each channel, selector, trigger mode and filter value at random and toggles the selected pad. Each sample is compared against the held level or the single pulse that the mode predicts, at the exact edge the latency rule gives. This separates level from edge behaviour, rising from falling, and both-edge from single-edge. Directed cases cover the rest:
- A two-cycle glitch against filter 4 separates filtering from simple delay, and a one-cycle dip at filter 0 shows the bypass.
- A selector past the last input in level-low mode shows the constant-low substitution, and selector 39 checks the top valid input.
- A selector switch between pads at different levels, and an invert flip, expose any leftover detector history.
- The same both-edge configuration is written to a build with both-edge and a build without it. This shows the override in one build and the falling-edge fallback in the other.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int NUM_CH   = 8;
  localparam int SEL_W    = 8;
  localparam int FLT_W    = 4;
  localparam int DATA_W   = 32;
  localparam int REG_AW   = 2;
  localparam int CH_PER_W = DATA_W / SEL_W;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             edge_en;
    logic             both_en;
    logic             inv_en;
    logic [FLT_W-1:0] flt;
  } chan_cfg_t;
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter bit BOTH_EN = 1'b1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [REG_AW-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [DATA_W-1:0]            rdata_o,
  output chan_cfg_t [NUM_CH-1:0]       cfg_o,
  output logic [NUM_CH-1:0]            chg_o
);
  logic [NUM_CH-1:0]             edge_q, inv_q, both_q;
  logic [NUM_CH-1:0][SEL_W-1:0]  sel_q;
  logic [NUM_CH-1:0][FLT_W-1:0]  flt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_q <= '0;
      inv_q  <= '0;
      sel_q  <= '0;
      flt_q  <= '0;
    end else if (we_i) begin
      case (addr_i)
        2'd0: begin
          edge_q <= wdata_i[NUM_CH-1:0];
          inv_q  <= wdata_i[2*NUM_CH +: NUM_CH];
        end
        2'd1: sel_q[CH_PER_W-1:0]        <= wdata_i;
        2'd2: sel_q[NUM_CH-1:CH_PER_W]   <= wdata_i;
        default: flt_q <= wdata_i;
      endcase
    end
  end

  generate
    if (BOTH_EN) begin : g_both
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                     both_q <= '0;
        else if (we_i && addr_i == 2'd0) both_q <= wdata_i[NUM_CH +: NUM_CH];
      end
    end else begin : g_no_both
      assign both_q = '0;
    end
  endgenerate

  always_comb begin
    case (addr_i)
      2'd0:    rdata_o = {8'h00, inv_q, both_q, edge_q};
      2'd1:    rdata_o = sel_q[CH_PER_W-1:0];
      2'd2:    rdata_o = sel_q[NUM_CH-1:CH_PER_W];
      default: rdata_o = flt_q;
    endcase
  end

  // per-channel change strobe: mode or selector differs from stored value
  always_comb begin
    for (int ch = 0; ch < NUM_CH; ch++) begin
      cfg_o[ch].sel     = sel_q[ch];
      cfg_o[ch].edge_en = edge_q[ch];
      cfg_o[ch].both_en = both_q[ch];
      cfg_o[ch].inv_en  = inv_q[ch];
      cfg_o[ch].flt     = flt_q[ch];
      chg_o[ch] = we_i &&
        ((addr_i == 2'd0 &&
          ({wdata_i[ch], wdata_i[NUM_CH+ch] & BOTH_EN, wdata_i[2*NUM_CH+ch]} !=
           {edge_q[ch], both_q[ch], inv_q[ch]})) ||
         (addr_i == REG_AW'(1 + ch / CH_PER_W) &&
          wdata_i[(ch % CH_PER_W)*SEL_W +: SEL_W] != sel_q[ch]));
    end
  end

  assert_sel_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd1) |=> (cfg_o[0].sel == $past(wdata_i[SEL_W-1:0])));

  assert_both_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd0) |=> (cfg_o[1].both_en == ($past(wdata_i[NUM_CH+1]) & BOTH_EN)));
endmodule

// File: rtl/gpio_irq_chan.sv
module gpio_irq_chan
  import gpio_irq_pkg::*;
#(
  parameter int NUM_IN = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IN-1:0] pad_i,
  input  chan_cfg_t         cfg_i,
  input  logic              chg_i,
  output logic              irq_o
);
  logic             pick, sync1_q, sync2_q, flt_q, prev_q, irq_q;
  logic [1:0]       quiet_q;
  logic [FLT_W-1:0] cnt_q, thr;
  logic             level_mode, pulse_mode, lvl, evt;

  always_comb begin
    pick = 1'b0;
    for (int i = 0; i < NUM_IN; i++)
      if (cfg_i.sel == SEL_W'(i)) pick = pad_i[i];
  end

  assign thr        = (cfg_i.flt == '0) ? FLT_W'(1) : cfg_i.flt;
  assign level_mode = !cfg_i.edge_en && !cfg_i.both_en;
  assign pulse_mode = cfg_i.edge_en && !cfg_i.both_en;
  assign lvl        = flt_q ^ cfg_i.inv_en;

  always_comb begin
    if (level_mode)         evt = lvl;
    else if (cfg_i.both_en) evt = lvl ^ prev_q;
    else                    evt = lvl & ~prev_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      flt_q   <= 1'b0;
      prev_q  <= 1'b0;
      irq_q   <= 1'b0;
      cnt_q   <= '0;
      quiet_q <= '0;
    end else begin
      sync1_q <= pick;
      sync2_q <= sync1_q;
      if (chg_i || quiet_q != 2'd0) begin
        // flush: reload history from the new path, emit nothing
        quiet_q <= chg_i ? 2'd3 : quiet_q - 2'd1;
        flt_q   <= sync2_q;
        cnt_q   <= '0;
        prev_q  <= sync2_q ^ cfg_i.inv_en;
        irq_q   <= level_mode && !chg_i && (sync2_q ^ cfg_i.inv_en);
      end else begin
        prev_q <= lvl;
        irq_q  <= evt;
        if (sync2_q == flt_q) begin
          cnt_q <= '0;
        end else if (cnt_q >= thr - FLT_W'(1)) begin
          flt_q <= sync2_q;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + FLT_W'(1);
        end
      end
    end
  end

  assign irq_o = irq_q;

  assert_oob_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(int'(cfg_i.sel) >= NUM_IN) |-> !sync1_q);

  assert_filter_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(flt_q) |-> (flt_q == $past(sync2_q)));

  assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_mode && irq_q) |=> (!irq_q || !pulse_mode));

  assert_cfg_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(chg_i) && !level_mode) |-> !irq_q);
endmodule

// File: rtl/gpio_irq_mux.sv
module gpio_irq_mux
  import gpio_irq_pkg::*;
#(
  parameter int NUM_IN       = 256,
  parameter bit BOTH_EDGE_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IN-1:0] pad_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic [7:0]        irq_o
);
  chan_cfg_t [NUM_CH-1:0] cfg;
  logic      [NUM_CH-1:0] chg;

  gpio_irq_regs #(.BOTH_EN(BOTH_EDGE_EN)) regs_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .cfg_o   (cfg),
    .chg_o   (chg)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      gpio_irq_chan #(.NUM_IN(NUM_IN)) chan_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pad_i  (pad_i),
        .cfg_i  (cfg[c]),
        .chg_i  (chg[c]),
        .irq_o  (irq_o[c])
      );
    end
  endgenerate
endmodule

// File: tb/gpio_irq_mux_tb_top.sv
module gpio_irq_mux_tb_top;
  localparam int TB_IN = 40;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [TB_IN-1:0] pad = '0;
  logic             we_a = 1'b0, we_b = 1'b0;
  logic [1:0]       addr_a = '0, addr_b = '0;
  logic [31:0]      wd_a = '0, wd_b = '0;
  logic [31:0]      rd_a, rd_b;
  logic [7:0]       irq_a, irq_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] sh [4];

  always #4 clk = ~clk;

  gpio_irq_mux #(.NUM_IN(TB_IN), .BOTH_EDGE_EN(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pad_i(pad), .reg_we_i(we_a), .reg_addr_i(addr_a),
    .reg_wdata_i(wd_a), .reg_rdata_o(rd_a), .irq_o(irq_a));

  gpio_irq_mux #(.NUM_IN(TB_IN), .BOTH_EDGE_EN(1'b0)) dut_nb_i (
    .clk_i(clk), .rst_ni(rst_n), .pad_i(pad), .reg_we_i(we_b), .reg_addr_i(addr_b),
    .reg_wdata_i(wd_b), .reg_rdata_o(rd_b), .irq_o(irq_b));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int which, input logic [1:0] a, input logic [31:0] d);
    if (which == 0) begin we_a = 1'b1; addr_a = a; wd_a = d; end
    else            begin we_b = 1'b1; addr_b = a; wd_b = d; end
    @(posedge clk);
    @(negedge clk);
    we_a = 1'b0;
    we_b = 1'b0;
  endtask

  task automatic rd(input int which, input logic [1:0] a, output logic [31:0] d);
    if (which == 0) addr_a = a; else addr_b = a;
    #1;
    d = (which == 0) ? rd_a : rd_b;
  endtask

  function automatic int lat_of(input int f);
    return 3 + ((f == 0) ? 1 : f);
  endfunction

  task automatic observe(input int which, input int ch, input int lat, input bit lvlm,
                         input bit oldl, input bit newl, input bit ev, input string req);
    for (int k = 1; k <= lat + 2; k++) begin
      logic got, exp;
      @(posedge clk);
      @(negedge clk);
      got = (which == 0) ? irq_a[ch] : irq_b[ch];
      exp = lvlm ? ((k >= lat) ? newl : oldl) : (k == lat && ev);
      chk(got == exp, req, 32'(got), 32'(exp));
    end
  endtask

  task automatic hold_check(input int ch, input bit exp, input int cycles, input string req);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      chk(irq_a[ch] == exp, req, 32'(irq_a[ch]), 32'(exp));
    end
  endtask

  task automatic cfg_ch(input int ch, input int sel, input bit e, input bit b, input bit i, input int f);
    int w;
    sh[0][ch] = e;
    sh[0][8+ch] = b;
    sh[0][16+ch] = i;
    wr(0, 2'd0, sh[0]);
    w = 1 + ch / 4;
    sh[w][(ch%4)*8 +: 8] = 8'(sel);
    wr(0, 2'(w), sh[w]);
    sh[3][ch*4 +: 4] = 4'(f);
    wr(0, 2'd3, sh[3]);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) sh[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(0, 2'(a), r);
      chk(r == 32'h0, "R1 reg", r, 32'h0);
    end
    chk(irq_a == 8'h0, "R1 irq", 32'(irq_a), 32'h0);

    // R2 register map readback
    wr(0, 2'd0, 32'hFFA55A3C); rd(0, 2'd0, r); chk(r == 32'h00A55A3C, "R2 w0", r, 32'h00A55A3C);
    wr(0, 2'd1, 32'h12345678); rd(0, 2'd1, r); chk(r == 32'h12345678, "R2 w1", r, 32'h12345678);
    wr(0, 2'd2, 32'h9ABCDEF0); rd(0, 2'd2, r); chk(r == 32'h9ABCDEF0, "R2 w2", r, 32'h9ABCDEF0);
    wr(0, 2'd3, 32'hC3D2E1F0); rd(0, 2'd3, r); chk(r == 32'hC3D2E1F0, "R2 w3", r, 32'hC3D2E1F0);
    for (int a = 0; a < 4; a++) wr(0, 2'(a), 32'h0);

    // R9 both bits absent in the reduced build
    wr(1, 2'd0, 32'hFFFFFFFF); rd(1, 2'd0, r); chk(r == 32'h00FF00FF, "R9 readback", r, 32'h00FF00FF);
    wr(1, 2'd0, 32'h0);
    repeat (6) @(negedge clk);

    // R8 both-edge overrides edge+invert on ch0 (sel 0 = pad 0)
    cfg_ch(0, 0, 1'b1, 1'b1, 1'b1, 0);
    wr(1, 2'd0, 32'h00010101);
    repeat (6) @(negedge clk);
    pad[0] = 1'b1; observe(0, 0, 4, 1'b0, 1'b0, 1'b0, 1'b1, "R8 rise");
    pad[0] = 1'b0; observe(0, 0, 4, 1'b0, 1'b0, 1'b0, 1'b1, "R8 fall");
    // R9 same bits act as falling-edge only
    pad[0] = 1'b1; observe(1, 0, 4, 1'b0, 1'b0, 1'b0, 1'b0, "R9 rise ignored");
    pad[0] = 1'b0; observe(1, 0, 4, 1'b0, 1'b0, 1'b0, 1'b1, "R9 fall");

    // R3 selector boundary and out-of-range
    cfg_ch(2, TB_IN - 1, 1'b0, 1'b0, 1'b0, 0);
    pad[TB_IN-1] = 1'b1; observe(0, 2, 4, 1'b1, 1'b0, 1'b1, 1'b0, "R3 top input");
    pad = '0;
    cfg_ch(2, TB_IN + 5, 1'b0, 1'b0, 1'b1, 0);
    hold_check(2, 1'b1, 4, "R3 oob low");
    pad = '1;
    hold_check(2, 1'b1, 8, "R3 oob pads high");
    pad = '0;
    repeat (6) @(negedge clk);

    // R5 glitch rejection, R4 filtered latency
    cfg_ch(3, 5, 1'b0, 1'b0, 1'b0, 4);
    pad[5] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    pad[5] = 1'b0;
    hold_check(3, 1'b0, 12, "R5 glitch rejected");
    pad[5] = 1'b1; observe(0, 3, 7, 1'b1, 1'b0, 1'b1, 1'b0, "R4 filter 4");
    // R5 filter 0: single-cycle dip passes
    cfg_ch(3, 5, 1'b0, 1'b0, 1'b0, 0);
    pad[5] = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      logic exp;
      @(posedge clk);
      @(negedge clk);
      if (k == 1) pad[5] = 1'b1;
      exp = (k == 4) ? 1'b0 : 1'b1;
      chk(irq_a[3] == exp, "R5 bypass", 32'(irq_a[3]), 32'(exp));
    end

    // R10 selector switch and invert flips make no event
    pad = '0;
    pad[7] = 1'b1;
    cfg_ch(1, 6, 1'b1, 1'b0, 1'b0, 0);
    hold_check(1, 1'b0, 2, "R10 setup");
    sh[1][15:8] = 8'd7; wr(0, 2'd1, sh[1]);
    hold_check(1, 1'b0, 10, "R10 sel switch");
    sh[0][17] = 1'b1; wr(0, 2'd0, sh[0]);
    hold_check(1, 1'b0, 8, "R10 inv on");
    sh[0][17] = 1'b0; wr(0, 2'd0, sh[0]);
    hold_check(1, 1'b0, 8, "R10 inv off");
    pad[7] = 1'b0; observe(0, 1, 4, 1'b0, 1'b0, 1'b0, 1'b0, "R7 fall ignored");
    pad[7] = 1'b1; observe(0, 1, 4, 1'b0, 1'b0, 1'b0, 1'b1, "R7 rise after switch");

    // random phase
    for (int it = 0; it < 40; it++) begin
      int ch, sel, mode, f, lat;
      bit e, b, inv, lvlm, cur, nv, ev, exp0;
      string req;
      ch = int'($urandom % 8);
      sel = int'($urandom % TB_IN);
      mode = int'($urandom % 5);
      f = int'($urandom % 4);
      e = (mode == 2 || mode == 3);
      b = (mode == 4);
      inv = (mode == 1 || mode == 3);
      lvlm = (mode < 2);
      req = lvlm ? "R6" : (b ? "R8" : "R7");
      pad = TB_IN'({$urandom, $urandom});
      cfg_ch(ch, sel, e, b, inv, f);
      lat = lat_of(f);
      cur = pad[sel];
      @(negedge clk);
      exp0 = lvlm ? (cur ^ inv) : 1'b0;
      chk(irq_a[ch] == exp0, {req, " initial"}, 32'(irq_a[ch]), 32'(exp0));
      for (int s = 0; s < 3; s++) begin
        nv = 1'($urandom);
        if (b)      ev = (nv != cur);
        else if (e) ev = (nv != cur) && ((nv ^ inv) == 1'b1);
        else        ev = 1'b0;
        pad[sel] = nv;
        observe(0, ch, lat, lvlm, cur ^ inv, nv ^ inv, ev, {req, " random R4"});
        cur = nv;
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule